// File: doc/BRIEF.md
# Single-Wire Shift-Register Character Display Transmitter

This block sends bytes to a character display controller that runs with a 4-bit data bus. Everything goes over one output wire. That wire drives the clock input of an external latching serial-in parallel-out shift register. It also drives the register's data input through a slow RC filter. The data value seen at each rising edge is therefore the level the wire has held for at least one filter delay. A short low-high pulse clocks in the previous level unchanged. A '1' is sent as a brief low blip. A '0' is sent as a low level held for a full delay, followed by a high level held for a full delay.

Each accepted byte is split into two nibbles, high nibble first. Each nibble is packed into an 8-bit frame together with the register-select flag and the backlight level. A marker bit leads every frame and later drives latch/enable. Two board variants are supported, chosen per byte:
- Hardware-clear: the board latches and clears the shift register on its own, so frames follow each other directly.
- Software-clear: the block holds the wire high for one delay to latch, drives it low for one delay to strobe enable, clocks in eight zeros with short pulses, and then recharges the data filter.

The display's busy flag cannot be read. Each byte therefore occupies at least a minimum number of cycles, and padding is added when the transfer finishes sooner. All delays are clock-cycle parameters.

Top module: `lcd1w_tx`

## Requirements
- R1: Every frame has this layout: bit 7 = 1 (marker), bit 6 = register select, bit 5 = backlight, bit 4 = D4, bit 3 = D5, bit 2 = D6, bit 1 = D7, bit 0 = 1.
- R2: A byte is sent as two frames. The first frame carries data bits 7..4 as D7..D4. The second carries data bits 3..0.
- R3: Frame bits go out MSB first, one rising edge on `line_out` per bit.
  - A '1' bit is low for PULSE_CYC cycles, then high for PULSE_CYC cycles.
  - A '0' bit is low for DELAY_CYC cycles, then high for DELAY_CYC cycles.
- R4: After reset `line_out` is high, `busy` is 0 and `in_ready` is 1. `line_out` stays high whenever the block is idle.
- R5: In software-clear mode (`in_hw_clear`=0), each frame is followed by a fixed sequence:
  - the wire stays high DELAY_CYC more cycles;
  - it goes low for DELAY_CYC;
  - it gives eight short rising edges (high PULSE_CYC, low PULSE_CYC between them) that clock zeros and leave the register empty;
  - it holds high for a further DELAY_CYC.
- R6: In hardware-clear mode (`in_hw_clear`=1), no latch or clear phase is inserted. The next frame starts right after the 8th bit.
- R7: A byte is accepted only when `in_valid` and `in_ready` are both high. `busy` then stays high for exactly max(MIN_CMD_CYC, transfer cycles). `in_valid` while busy starts nothing.
- R8: Data, register select, backlight and mode are captured at acceptance. Changes to them while busy have no effect on the frames sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block idle, byte can be taken |
| in_data | input | 8 | Byte for the display |
| in_rs | input | 1 | Register-select flag for this byte |
| in_backlight | input | 1 | Backlight level for this byte |
| in_hw_clear | input | 1 | 1 = board self-clears, 0 = software clear sequence |
| busy | output | 1 | Transfer or padding in progress |
| line_out | output | 1 | The single wire to the shift register |

## Verification
The in-line assertions watch several properties on every cycle:
- the idle level of the wire;
- that a transfer begins only on a valid handshake;
- that busy never drops before the minimum span;
- that every frame starts with a marker one;
- that no latch or clear phase appears in hardware-clear mode;
- that captured fields stay frozen during a transfer.

Some behaviour only the bench scenarios can show. The bench decodes the wire through a model of the RC data filter and the shift register. From that it recovers the frames actually latched and confirms that the software clear leaves the register empty. It also checks the exact busy length against timing computed from the bit values, and shows that inputs offered mid-transfer leave the frames untouched.

// File: rtl/lcd1w_pkg.sv
// Shared types for the single-wire display transmitter.
package lcd1w_pkg;

    localparam int FRAME_W = 8;

    // Phases of the wire sequencer; each non-idle phase fixes the line level.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_LATCH_HI,
        ST_LATCH_LO,
        ST_CLR_HI,
        ST_CLR_LO,
        ST_RECHARGE,
        ST_PAD
    } tx_state_e;

endpackage

// File: rtl/lcd1w_frame_pack.sv
// Builds one 8-bit shift-register frame from a nibble and the two flags.
// Assumes the fixed wiring: marker on bit 7, D7..D4 reversed onto bits 1..4.
module lcd1w_frame_pack
    import lcd1w_pkg::*;
(
    input  logic [3:0]         nib,
    input  logic               rs,
    input  logic               bl,
    output logic [FRAME_W-1:0] frame
);
    // Fixed fields: marker, select, backlight, spare one.
    assign frame[7] = 1'b1;
    assign frame[6] = rs;
    assign frame[5] = bl;
    assign frame[0] = 1'b1;

    // Data bits land in reverse order: nibble bit g goes to frame bit 4-g.
    for (genvar g = 0; g < 4; g++) begin : g_data
        assign frame[4-g] = nib[g];
    end
endmodule

// File: rtl/lcd1w_phase_timer.sv
// Down-counter that times one wire phase; done is high in its last cycle.
// Assumes load values are duration minus one.
module lcd1w_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    // Load on phase entry, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/lcd1w_span_counter.sv
// Counts busy cycles since acceptance; reached flags that the minimum span
// ends in the current cycle or has already ended.
// Assumes clear coincides with the accepting edge.
module lcd1w_span_counter #(
    parameter int MIN_CYC = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic reached
);
    localparam int SW = $clog2(MIN_CYC + 1);
    localparam logic [SW-1:0] LAST = SW'(MIN_CYC - 1);

    logic [SW-1:0] el;

    // Restart on acceptance, saturate once the minimum is reached.
    always_ff @(posedge clk) begin
        if (!rst_n)                el <= '0;
        else if (clear)            el <= '0;
        else if (run && !reached)  el <= el + 1'b1;
    end

    assign reached = (el >= LAST);
endmodule

// File: rtl/lcd1w_tx.sv
// Single-wire transmitter for a 4-bit character display behind a latching
// shift register. Sequences bit, latch, clear and padding phases on line_out.
// Assumes DELAY_CYC covers the board's RC filter and PULSE_CYC is well below it.
module lcd1w_tx
    import lcd1w_pkg::*;
#(
    parameter int DELAY_CYC   = 8,
    parameter int PULSE_CYC   = 2,
    parameter int MIN_CMD_CYC = 120
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_rs,
    input  logic       in_backlight,
    input  logic       in_hw_clear,
    output logic       busy,
    output logic       line_out
);
    localparam int TMAX = (DELAY_CYC > PULSE_CYC) ? DELAY_CYC : PULSE_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] D_LD = TW'(DELAY_CYC - 1);
    localparam logic [TW-1:0] P_LD = TW'(PULSE_CYC - 1);
    localparam logic [2:0] LAST_CLR = 3'd7;

    tx_state_e state, st_n;
    logic [2:0] bit_idx, bit_n, clr_idx, clr_n;
    logic       nib_sel, nib_n;
    logic [7:0] data_q;
    logic       rs_q, bl_q, hw_q;
    logic       accept, frame_end, tmr_load, tmr_done, span_reached;
    logic [TW-1:0] tmr_val;
    logic [FRAME_W-1:0] frame_hi, frame_lo, cur_frame;
    logic       cur_bit;

    lcd1w_frame_pack u_pack_hi (
        .nib(data_q[7:4]), .rs(rs_q), .bl(bl_q), .frame(frame_hi));
    lcd1w_frame_pack u_pack_lo (
        .nib(data_q[3:0]), .rs(rs_q), .bl(bl_q), .frame(frame_lo));

    lcd1w_phase_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .done(tmr_done));

    lcd1w_span_counter #(.MIN_CYC(MIN_CMD_CYC)) u_span (
        .clk(clk), .rst_n(rst_n), .clear(accept), .run(busy),
        .reached(span_reached));

    assign cur_frame = nib_sel ? frame_lo : frame_hi;
    assign cur_bit   = cur_frame[bit_idx];
    assign in_ready  = (state == ST_IDLE);
    assign busy      = !in_ready;
    assign line_out  = !(state inside {ST_BIT_LO, ST_LATCH_LO, ST_CLR_LO});

    // Next-phase selection and timer reload for each phase.
    always_comb begin
        st_n      = state;
        bit_n     = bit_idx;
        clr_n     = clr_idx;
        nib_n     = nib_sel;
        tmr_load  = 1'b0;
        tmr_val   = P_LD;
        accept    = 1'b0;
        frame_end = 1'b0;
        unique case (state)
            ST_IDLE: if (in_valid) begin
                accept   = 1'b1;
                st_n     = ST_BIT_LO;
                bit_n    = 3'd7;
                nib_n    = 1'b0;
                tmr_load = 1'b1;
                tmr_val  = P_LD;            // marker is always a one
            end
            ST_BIT_LO: if (tmr_done) begin
                st_n     = ST_BIT_HI;
                tmr_load = 1'b1;
                tmr_val  = cur_bit ? P_LD : D_LD;
            end
            ST_BIT_HI: if (tmr_done) begin
                if (bit_idx != 3'd0) begin
                    bit_n    = bit_idx - 3'd1;
                    st_n     = ST_BIT_LO;
                    tmr_load = 1'b1;
                    tmr_val  = cur_frame[bit_idx - 3'd1] ? P_LD : D_LD;
                end else if (!hw_q) begin
                    st_n     = ST_LATCH_HI;
                    tmr_load = 1'b1;
                    tmr_val  = D_LD;
                end else begin
                    frame_end = 1'b1;
                end
            end
            ST_LATCH_HI: if (tmr_done) begin
                st_n     = ST_LATCH_LO;
                tmr_load = 1'b1;
                tmr_val  = D_LD;
            end
            ST_LATCH_LO: if (tmr_done) begin
                st_n     = ST_CLR_HI;
                clr_n    = 3'd0;
                tmr_load = 1'b1;
                tmr_val  = P_LD;
            end
            ST_CLR_HI: if (tmr_done) begin
                tmr_load = 1'b1;
                if (clr_idx == LAST_CLR) begin
                    st_n    = ST_RECHARGE;
                    tmr_val = D_LD;
                end else begin
                    st_n    = ST_CLR_LO;
                    tmr_val = P_LD;
                end
            end
            ST_CLR_LO: if (tmr_done) begin
                st_n     = ST_CLR_HI;
                clr_n    = clr_idx + 3'd1;
                tmr_load = 1'b1;
                tmr_val  = P_LD;
            end
            ST_RECHARGE: if (tmr_done) frame_end = 1'b1;
            ST_PAD: if (span_reached) st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
        if (frame_end) begin
            if (!nib_sel) begin
                nib_n    = 1'b1;
                bit_n    = 3'd7;
                st_n     = ST_BIT_LO;
                tmr_load = 1'b1;
                tmr_val  = P_LD;
            end else begin
                st_n = span_reached ? ST_IDLE : ST_PAD;
            end
        end
    end

    // Sequencer state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_idx <= 3'd7;
            clr_idx <= 3'd0;
            nib_sel <= 1'b0;
        end else begin
            state   <= st_n;
            bit_idx <= bit_n;
            clr_idx <= clr_n;
            nib_sel <= nib_n;
        end
    end

    // Capture of the byte and its attributes at acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            rs_q   <= 1'b0;
            bl_q   <= 1'b0;
            hw_q   <= 1'b0;
        end else if (accept) begin
            data_q <= in_data;
            rs_q   <= in_rs;
            bl_q   <= in_backlight;
            hw_q   <= in_hw_clear;
        end
    end

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> line_out);                                            // R4
    AST_START_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(in_valid));                               // R7
    AST_MIN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(span_reached));                           // R7
    AST_FRAME_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BIT_LO && bit_idx == 3'd7) |-> cur_bit);           // R1
    AST_HW_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hw_q) |-> !(state inside {ST_LATCH_HI, ST_LATCH_LO,
                                          ST_CLR_HI, ST_CLR_LO, ST_RECHARGE})); // R6
    AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(data_q) && $stable(hw_q)
                                   && $stable(rs_q) && $stable(bl_q))); // R8
endmodule

// File: tb/lcd1w_tx_bench.sv
`timescale 1ns/1ps
module lcd1w_tx_bench;
    localparam int D   = 8;
    localparam int P   = 2;
    localparam int MIN = 120;
    localparam int NV  = 8;
    // {hw_clear, rs, backlight, data[7:0]}
    localparam logic [10:0] VECS [NV] = '{
        {1'b1, 1'b0, 1'b0, 8'hFF}, {1'b0, 1'b0, 1'b0, 8'h00},
        {1'b0, 1'b1, 1'b0, 8'hA5}, {1'b1, 1'b0, 1'b1, 8'h3C},
        {1'b1, 1'b0, 1'b0, 8'h00}, {1'b0, 1'b0, 1'b1, 8'hFF},
        {1'b1, 1'b1, 1'b1, 8'h81}, {1'b0, 1'b1, 1'b1, 8'h5A}};

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_rs = 1'b0, in_backlight = 1'b0, in_hw_clear = 1'b0;
    logic [7:0] in_data = '0;
    logic in_ready, busy, line_out;

    int checks = 0, fails = 0, cycles = 0;

    lcd1w_tx #(.DELAY_CYC(D), .PULSE_CYC(P), .MIN_CMD_CYC(MIN)) u_lcd1w_tx (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_rs(in_rs), .in_backlight(in_backlight),
        .in_hw_clear(in_hw_clear), .busy(busy), .line_out(line_out));

    always #2.5 clk = ~clk;

    // Receiver model: RC data filter plus shift register, sampled at negedge.
    logic mon_clr = 1'b1, mode_hw = 1'b0;
    logic prev_line = 1'b1, filt = 1'b1;
    int   run = 0, edge_cnt = 0, nframes = 0, busy_cyc = 0;
    logic [7:0] sr = '0, sr_after = 8'hEE;
    logic [7:0] frames [4];

    always @(negedge clk) begin
        cycles++;
        if (mon_clr) begin
            edge_cnt = 0; sr = '0; nframes = 0; busy_cyc = 0; sr_after = 8'hEE;
        end else begin
            if (busy) busy_cyc++;
            if (!prev_line && line_out) begin
                sr = {sr[6:0], filt};
                edge_cnt++;
                if (edge_cnt == 8) begin
                    if (nframes < 4) frames[nframes] = sr;
                    nframes++;
                    if (mode_hw) begin edge_cnt = 0; sr = '0; end
                end else if (edge_cnt == 16) begin
                    sr_after = sr; edge_cnt = 0;
                end
            end
        end
        if (line_out == prev_line) begin if (run < 100000) run++; end
        else run = 1;
        if (run >= D) filt = line_out;
        prev_line = line_out;
    end

    function automatic logic [7:0] exp_frame(logic [3:0] n, logic rs, logic bl);
        return {1'b1, rs, bl, n[0], n[1], n[2], n[3], 1'b1};   // R1 layout
    endfunction

    function automatic int frame_cyc(logic [7:0] f, logic hw);
        int s = 0;
        for (int i = 0; i < 8; i++) s += f[i] ? 2*P : 2*D;     // R3 bit timing
        if (!hw) s += 3*D + 15*P;                               // R5 clear sequence
        return s;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Send one byte, optionally offering junk input while busy.
    task automatic send(input logic [10:0] v, input bit junk);
        mode_hw = v[10];
        mon_clr = 1'b1;
        @(negedge clk);
        mon_clr = 1'b0;
        in_hw_clear = v[10]; in_rs = v[9]; in_backlight = v[8]; in_data = v[7:0];
        in_valid = 1'b1;
        @(negedge clk);
        if (junk) begin
            in_data = ~v[7:0]; in_rs = ~v[9]; in_backlight = ~v[8]; in_hw_clear = ~v[10];
            repeat (20) @(negedge clk);
        end
        in_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    task automatic verify(input logic [10:0] v, input string tag);
        logic [7:0] fh, fl;
        int t;
        fh = exp_frame(v[7:4], v[9], v[8]);
        fl = exp_frame(v[3:0], v[9], v[8]);
        t = frame_cyc(fh, v[10]) + frame_cyc(fl, v[10]);
        if (t < MIN) t = MIN;
        check(nframes == 2, {tag, " R2 frame count"}, nframes, 2);
        check(frames[0] == fh, {tag, " R1 R2 R3 high-nibble frame"}, frames[0], fh);
        check(frames[1] == fl, {tag, " R1 R2 R3 low-nibble frame"}, frames[1], fl);
        check(busy_cyc == t, {tag, " R7 busy length"}, busy_cyc, t);
        if (!v[10]) check(sr_after == 8'h00, {tag, " R5 register cleared"}, sr_after, 0);
        else        check(edge_cnt == 0, {tag, " R6 no extra edges"}, edge_cnt, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(line_out == 1'b1, "R4 reset line", line_out, 1);
        check(busy == 1'b0, "R4 reset busy", busy, 0);
        check(in_ready == 1'b1, "R4 reset ready", in_ready, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(line_out == 1'b1, "R4 idle line", line_out, 1);

        for (int i = 0; i < NV; i++) begin
            send(VECS[i], 1'b0);
            verify(VECS[i], "table");
        end

        // R8/R7: inputs changed and valid held while busy must not matter.
        send({1'b0, 1'b1, 1'b0, 8'h96}, 1'b1);
        verify({1'b0, 1'b1, 1'b0, 8'h96}, "R8 busy-input");
        repeat (300) @(negedge clk);
        check(nframes == 2, "R7 no second transfer", nframes, 2);
        check(line_out == 1'b1 && !busy, "R4 idle after transfer", line_out, 1);

        // R6: hardware-clear busy-input run keeps frames.
        send({1'b1, 1'b0, 1'b1, 8'h0F}, 1'b1);
        verify({1'b1, 1'b0, 1'b1, 8'h0F}, "R6 R8 hw busy-input");

        // R4: reset in the middle of a transfer returns to idle.
        in_hw_clear = 1'b0; in_data = 8'h00; in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(!busy && line_out && in_ready, "R4 mid-transfer reset", busy, 0);
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles >= 200000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<200000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule